// File: doc/BRIEF.md
# Event Frame Serializer

The serializer takes triggered events from an upstream event buffer and transmits each as a fixed-length serial frame on one output line, one bit per clock. A frame carries a two-bit start header, then a latency-error flag and a buffer-overflow flag, then the 8-bit pipeline address of the event, then the hit bit of every channel with no zero suppression. With the default 128 channels a frame is 140 clock cycles long.

The upstream buffer raises `evt_valid` while it holds an event and presents that event's fields. The serializer answers with a single-cycle `evt_pop` when it takes the event. It takes an event only when it is idle or on the last bit of the current frame. Queued events therefore leave as back-to-back frames, each with its own header. When no event is waiting, the line rests at logic 0.

Top module: `esr_frame_serializer`

## Requirements
- R1: While no frame is in progress, including straight after reset, `ser_out` is 0.
- R2: `evt_pop` is 1 exactly when `evt_valid` is 1 and the serializer is either idle or sending the last bit (bit index 139) of a frame. It lasts one cycle per event taken.
- R3: The first two bits of a frame (indices 0 and 1) are both 1. Bit 0 appears on `ser_out` in the cycle after the `evt_pop` cycle.
- R4: Bit index 2 carries `evt_lat_err` and bit index 3 carries `evt_ovf_err`, as sampled in the `evt_pop` cycle.
- R5: Bit indices 4 to 11 carry `evt_addr`, most significant bit first.
- R6: Bit indices 12 to 139 carry `evt_hits`, channel 127 first and channel 0 last.
- R7: A frame lasts exactly 140 cycles. If an event is waiting on the last bit, the next frame's first start bit follows in the very next cycle.
- R8: Event inputs presented in any cycle without `evt_pop` have no effect on the bits sent.
- R9: An asserted `rst_n` (active low) forces `ser_out` to 0 at once and abandons any frame in progress. After release, the serializer is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Buffer holds an event |
| evt_lat_err | input | 1 | Latency error flag of presented event |
| evt_ovf_err | input | 1 | Buffer overflow flag of presented event |
| evt_addr | input | 8 | Pipeline address of presented event |
| evt_hits | input | 128 | Channel hit bits, bit n is channel n |
| evt_pop | output | 1 | Event taken this cycle |
| ser_out | output | 1 | Serial frame output |

## Verification
The bench builds the block with its default parameters: 128 channels, an 8-bit address and a 2-bit header, which gives the full 140-cycle frame. These values exercise the bit counter over its whole range, including the wrap from the last channel bit straight into a new header. They also cover the top channel and address bits being sent first. Random gaps in the valid signal and random filler data on the event inputs outside pop cycles exercise the idle return, the pop window and the rule that unsampled inputs are ignored. A reset applied in the middle of a frame covers abandoning a frame.

// File: rtl/esr_pkg.sv
package esr_pkg;
  typedef enum logic {
    SER_IDLE = 1'b0,
    SER_SEND = 1'b1
  } ser_state_e;
endpackage

// File: rtl/esr_frame_pack.sv
module esr_frame_pack #(
  parameter int NUM_CH  = 128,
  parameter int ADDR_W  = 8,
  parameter int START_W = 2,
  parameter int FRAME_W = START_W + 2 + ADDR_W + NUM_CH
) (
  input  logic              lat_err,
  input  logic              ovf_err,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_CH-1:0] hits,
  output logic [FRAME_W-1:0] frame
);
  localparam int LAT_POS = FRAME_W - START_W - 1;
  localparam int OVF_POS = LAT_POS - 1;

  // header bits, all ones, at the top of the frame
  genvar g;
  generate
    for (g = 0; g < START_W; g++) begin : g_start
      assign frame[FRAME_W-1-g] = 1'b1;
    end
  endgenerate

  assign frame[LAT_POS]                  = lat_err;
  assign frame[OVF_POS]                  = ovf_err;
  assign frame[OVF_POS-1 -: ADDR_W]      = addr;
  assign frame[NUM_CH-1:0]               = hits;
endmodule

// File: rtl/esr_bit_counter.sv
module esr_bit_counter #(
  parameter int FRAME_W = 140,
  parameter int CNT_W   = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)
      cnt_d = '0;
    else if (adv && !last)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clear || adv)
      cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign last = (cnt_q == CNT_W'(FRAME_W - 1));

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_W - 1));
endmodule

// File: rtl/esr_shifter.sv
module esr_shifter #(
  parameter int FRAME_W = 140
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic [FRAME_W-1:0] din,
  output logic               msb
);
  logic [FRAME_W-1:0] sh_d;
  logic [FRAME_W-1:0] sh_q;

  always_comb begin
    sh_d = sh_q;
    if (load)
      sh_d = din;
    else if (shift)
      sh_d = {sh_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sh_q <= '0;
    else if (load || shift)
      sh_q <= sh_d;
  end

  assign msb = sh_q[FRAME_W-1];
endmodule

// File: rtl/esr_frame_serializer.sv
module esr_frame_serializer #(
  parameter int NUM_CH  = 128,
  parameter int ADDR_W  = 8,
  parameter int START_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic              evt_lat_err,
  input  logic              evt_ovf_err,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [NUM_CH-1:0] evt_hits,
  output logic              evt_pop,
  output logic              ser_out
);
  import esr_pkg::*;

  localparam int FRAME_W = START_W + 2 + ADDR_W + NUM_CH;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int GAP_W   = $clog2(FRAME_W + 2);

  ser_state_e         state_d, state_q;
  logic               take;
  logic               last_bit;
  logic [CNT_W-1:0]   bit_cnt;
  logic               sh_msb;
  logic [FRAME_W-1:0] frame;

  esr_frame_pack #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .START_W(START_W),
    .FRAME_W(FRAME_W)
  ) u_pack (
    .lat_err(evt_lat_err),
    .ovf_err(evt_ovf_err),
    .addr   (evt_addr),
    .hits   (evt_hits),
    .frame  (frame)
  );

  esr_bit_counter #(
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(take),
    .adv  (state_q == SER_SEND),
    .cnt  (bit_cnt),
    .last (last_bit)
  );

  esr_shifter #(
    .FRAME_W(FRAME_W)
  ) u_sh (
    .clk  (clk),
    .rst_n(rst_n),
    .load (take),
    .shift((state_q == SER_SEND) && !take),
    .din  (frame),
    .msb  (sh_msb)
  );

  // pop window: idle, or last bit of the running frame
  assign take = evt_valid && ((state_q == SER_IDLE) || last_bit);

  always_comb begin
    state_d = state_q;
    case (state_q)
      SER_IDLE: if (take) state_d = SER_SEND;
      SER_SEND: if (last_bit && !take) state_d = SER_IDLE;
      default:  state_d = SER_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= SER_IDLE;
    else
      state_q <= state_d;
  end

  assign evt_pop = take;
  assign ser_out = (state_q == SER_SEND) && sh_msb;

  // cycles since the last pop, saturating; used only by the checks below
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gap_q <= GAP_W'(FRAME_W + 1);
    else if (evt_pop)
      gap_q <= GAP_W'(1);
    else if (gap_q <= GAP_W'(FRAME_W))
      gap_q <= gap_q + 1'b1;
  end

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q > GAP_W'(FRAME_W)) |-> !ser_out);

  // R2
  pop_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pop |-> (gap_q >= GAP_W'(FRAME_W)));

  // R2
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pop |-> evt_valid);

  // R3
  hdr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q >= GAP_W'(1) && gap_q <= GAP_W'(START_W)) |-> ser_out);

  // R7
  frame_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q < GAP_W'(FRAME_W) && gap_q != '0) |-> !evt_pop);
endmodule

// File: tb/esr_frame_serializer_test.sv
`timescale 1ns/1ps
module esr_frame_serializer_test;
  localparam int FW = 140;

  typedef struct packed {
    logic         lat;
    logic         ovf;
    logic [7:0]   addr;
    logic [127:0] hits;
  } ev_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         evt_valid;
  logic         evt_lat_err;
  logic         evt_ovf_err;
  logic [7:0]   evt_addr;
  logic [127:0] evt_hits;
  logic         evt_pop;
  logic         ser_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  ev_t           q[$];
  logic [FW-1:0] cur;
  int            pos;

  always #2.5 clk = ~clk;

  esr_frame_serializer uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid),
    .evt_lat_err(evt_lat_err), .evt_ovf_err(evt_ovf_err),
    .evt_addr(evt_addr), .evt_hits(evt_hits),
    .evt_pop(evt_pop), .ser_out(ser_out)
  );

  function automatic logic [FW-1:0] mk_frame(ev_t e);
    logic [FW-1:0] f;
    f[FW-1] = 1'b1;
    f[FW-2] = 1'b1;
    f[FW-3] = e.lat;
    f[FW-4] = e.ovf;
    for (int i = 0; i < 8; i++) f[FW-5-i] = e.addr[7-i];
    for (int c = 0; c < 128; c++) f[c] = e.hits[c];
    return f;
  endfunction

  function automatic string req_of(int p);
    if (p == 0) return "R1";
    if (p <= 2) return "R3";
    if (p <= 4) return "R4";
    if (p <= 12) return "R5";
    return "R6";
  endfunction

  function automatic ev_t rnd_ev();
    ev_t e;
    e.lat  = 1'($urandom);
    e.ovf  = 1'($urandom);
    e.addr = 8'($urandom);
    e.hits = {$urandom, $urandom, $urandom, $urandom};
    return e;
  endfunction

  task automatic check(bit ok, string req, logic act, logic exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s pos=%0d actual=%0b expected=%0b", req, what, pos, act, exp);
    end
  endtask

  // one clock cycle: check output, drive inputs, check pop, advance the model
  task automatic step(bit allow_valid);
    logic exp_s;
    logic exp_p;
    bit   elig;
    ev_t  j;
    @(negedge clk);
    exp_s = (pos > 0) ? cur[FW-pos] : 1'b0;
    check(ser_out === exp_s, req_of(pos), ser_out, exp_s, "ser_out");
    elig = (pos == 0) || (pos == FW);
    evt_valid = allow_valid && (q.size() > 0);
    if (elig && evt_valid) begin
      {evt_lat_err, evt_ovf_err, evt_addr, evt_hits} = q[0];
    end else begin
      // R8: filler data outside pop cycles must not reach the line
      j = rnd_ev();
      {evt_lat_err, evt_ovf_err, evt_addr, evt_hits} = j;
    end
    #1;
    exp_p = evt_valid && elig;
    check(evt_pop === exp_p, (pos == FW) ? "R7" : "R2", evt_pop, exp_p, "evt_pop");
    if (exp_p) begin
      cur = mk_frame(q[0]);
      void'(q.pop_front());
      pos = 1;
    end else if (elig) begin
      pos = 0;
    end else begin
      pos = pos + 1;
    end
  endtask

  task automatic run_until_idle();
    int n = 0;
    while ((q.size() > 0 || pos != 0) && n < 20000) begin
      step(1'b1);
      n++;
    end
    repeat (3) step(1'b1);
  endtask

  initial begin
    ev_t e;
    void'($urandom(32'h5EED_0011));
    rst_n = 1'b0;
    evt_valid = 1'b0;
    evt_lat_err = 1'b0;
    evt_ovf_err = 1'b0;
    evt_addr = '0;
    evt_hits = '0;
    pos = 0;
    cur = '0;
    repeat (3) @(negedge clk);
    #1;
    // R9: reset state
    check(ser_out === 1'b0, "R9", ser_out, 1'b0, "ser_out in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1'b1);

    // directed patterns: error flags, address ends, channel ends
    e.lat = 1'b1; e.ovf = 1'b0; e.addr = 8'hA5; e.hits = '1;              q.push_back(e);
    run_until_idle();
    e.lat = 1'b0; e.ovf = 1'b1; e.addr = 8'h80; e.hits = 128'h1;          q.push_back(e);
    run_until_idle();
    e.lat = 1'b0; e.ovf = 1'b0; e.addr = 8'h01;
    e.hits = {1'b1, 127'h0};                                              q.push_back(e);
    run_until_idle();

    // R7: back-to-back frames
    e.lat = 1'b1; e.ovf = 1'b1; e.addr = 8'hFF;
    e.hits = {64{2'b10}};                                                 q.push_back(e);
    e.lat = 1'b0; e.ovf = 1'b0; e.addr = 8'h00; e.hits = '0;              q.push_back(e);
    e.lat = 1'b1; e.ovf = 1'b0; e.addr = 8'h3C;
    e.hits = {64{2'b01}};                                                 q.push_back(e);
    run_until_idle();

    // R9: reset in the middle of a frame
    q.push_back(rnd_ev());
    q.push_back(rnd_ev());
    repeat (40) step(1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    evt_valid = 1'b0;
    #1;
    check(ser_out === 1'b0, "R9", ser_out, 1'b0, "ser_out after mid-frame reset");
    pos = 0;
    @(negedge clk);
    rst_n = 1'b1;
    run_until_idle();

    // random stream with gaps in valid
    for (int k = 0; k < 40; k++) q.push_back(rnd_ev());
    for (int n = 0; n < 20000 && (q.size() > 0 || pos != 0); n++)
      step(($urandom % 4) != 0);
    for (int k = 0; k < 12; k++) begin
      q.push_back(rnd_ev());
      repeat ($urandom % 200) step(1'b0);
    end
    run_until_idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule